// File: doc/BRIEF.md
# PTP Receive Classifier and Timestamp Prefixer

This block sits on a 64-bit AXI4-Stream receive path. Each frame arrives with an 80-bit receive timestamp that is valid while the frame's first beat is presented. The block reads the Ethernet and IPv4/UDP header bytes to decide whether the frame is a PTP message. It then sends a two-word status prefix downstream ahead of the frame. The prefix carries the timestamp and a one-bit PTP qualifier, and the frame data follows unchanged. Every frame gets the prefix, whether or not it is PTP, so software always receives the arrival time.

Header beats are held in a small beat buffer until the classification is settled or the frame ends, because the qualifier must be known before the prefix leaves. The control path is the `ptp_rx_tagger` state machine:

- `ST_COLLECT` accepts beats into the buffer. It moves to `ST_PRE_LO` when the accepted beat settles the class or carries tlast.
- `ST_PRE_LO` sends the low timestamp word and moves to `ST_PRE_HI` on output handshake.
- `ST_PRE_HI` sends the second word and moves to `ST_DRAIN` on output handshake.
- `ST_DRAIN` forwards buffered and newly arriving beats of the same frame. It returns to `ST_COLLECT` when the beat carrying tlast leaves.

The header walker `ptp_hdr_classify` steps through `CL_ETH_ADDR`, `CL_ETH_TYPE`, `CL_IP_PROTO`, `CL_IP_DST_HI` and `CL_UDP_PORT`, one state per accepted beat. It returns to `CL_ETH_ADDR` on any final decision or on tlast. The parameter BUF_DEPTH, at least 6, sets the buffer size.

Top module: `ptp_rx_tagger`

## Requirements
- R1: The first output word of every frame carries bits [63:0] of the timestamp sampled with the frame's first accepted input beat. Its tkeep is 0xFF and its tlast is 0.
- R2: In the second output word, bits [15:0] carry timestamp bits [79:64] and bit 31 is the PTP qualifier. Bits [30:16] and [63:32] are 0, tkeep is 0xFF and tlast is 0.
- R3: From the third output word on, the frame's input beats appear in order with tdata, tkeep and tlast unchanged.
- R4: The qualifier is 1 when the EtherType equals 0x88F7. Byte n of the frame is tdata[8(n mod 8)+7 : 8(n mod 8)] of beat n/8, and the EtherType is byte 12 (high) and byte 13 (low).
- R5: The qualifier is 1 when all of the following hold:
  - the EtherType is 0x0800;
  - byte 14 is 0x45;
  - the protocol (byte 23) is 17;
  - the destination address (bytes 30..33) is 224.0.1.129 to 224.0.1.132 or 224.0.0.107;
  - the UDP destination port (bytes 36..37, high first) is 319 or 320.
- R6: The qualifier is 0 when any of those fields differs, or when the EtherType is neither 0x88F7 nor 0x0800.
- R7: A frame whose tlast arrives before its class is settled gets qualifier 0. It still gets the full prefix and all of its data.
- R8: s_tready is low in these cases:
  - while a prefix word is offered;
  - from acceptance of a frame's tlast until that frame's last output word is accepted;
  - whenever the buffer is full.
  
  After reset, with the buffer empty, s_tready is high and m_tvalid is low.
- R9: While m_tvalid is high and m_tready is low, the output word stays unchanged and valid.
- R10: The prefix is offered only after the beat that settles the class, or the tlast beat, has been accepted. That beat is:
  - beat 1 for a non-IPv4 EtherType or a wrong byte 14;
  - beat 2 for a wrong protocol;
  - beat 3 for a wrong address high half;
  - beat 4 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_in | input | 80 | Receive timestamp, valid with the frame's first beat |
| s_tdata | input | 64 | Input stream data |
| s_tkeep | input | 8 | Input byte enables |
| s_tlast | input | 1 | Input end of frame |
| s_tvalid | input | 1 | Input valid |
| s_tready | output | 1 | Input ready |
| m_tdata | output | 64 | Output stream data (prefix, then frame) |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Output end of frame |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |

## Verification
The following are checked on every cycle:
- the prefix format and the timestamp it carries (R1, R2);
- the closed input during the prefix and after a frame's tlast (R8);
- output stability under backpressure (R9).

To do this, the bound checker tracks word positions and the first-beat timestamp from the ports. The qualifier decision for each header pattern cannot be observed without knowing the frame contents: EtherType, IPv4 fields, the address list, port numbers and truncated frames. The same holds for the point at which the prefix starts and for the integrity of the forwarded data. Only the directed scenarios show these, by comparing whole output frames and the count of accepted beats before the first prefix word.

// File: rtl/ptp_rx_pkg.sv
package ptp_rx_pkg;

    localparam int unsigned BEAT_W  = 64;
    localparam int unsigned KEEP_W  = BEAT_W / 8;
    localparam int unsigned TS_W    = 80;
    localparam int unsigned TS_HI_W = TS_W - BEAT_W;

    localparam logic [15:0] ETYPE_PTP    = 16'h88F7;
    localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
    localparam logic [7:0]  IPV4_VER_IHL = 8'h45;
    localparam logic [7:0]  PROTO_UDP    = 8'd17;
    localparam logic [15:0] PORT_EVENT   = 16'd319;
    localparam logic [15:0] PORT_GENERAL = 16'd320;
    localparam logic [7:0]  MC_OCT1      = 8'd224;
    localparam logic [7:0]  MC_OCT2      = 8'd0;
    localparam logic [7:0]  MC_PDELAY_O3 = 8'd0;
    localparam logic [7:0]  MC_PDELAY_O4 = 8'd107;
    localparam logic [7:0]  MC_MAIN_O3   = 8'd1;
    localparam logic [7:0]  MC_MAIN_LO   = 8'd129;
    localparam logic [7:0]  MC_MAIN_HI   = 8'd132;

    typedef struct packed {
        logic [BEAT_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic              last;
    } beat_t;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_PRE_LO,
        ST_PRE_HI,
        ST_DRAIN
    } tag_state_e;

    typedef enum logic [2:0] {
        CL_ETH_ADDR,
        CL_ETH_TYPE,
        CL_IP_PROTO,
        CL_IP_DST_HI,
        CL_UDP_PORT
    } cls_state_e;

endpackage

// File: rtl/ptp_hdr_classify.sv
module ptp_hdr_classify
    import ptp_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat_fire,
    input  logic [31:0] hdr_hi,      // bytes 4..7 of the beat
    input  logic [15:0] hdr_lo,      // bytes 0..1 of the beat
    input  logic        beat_last,
    output logic        final_now,
    output logic        ptp_now
);

    cls_state_e cls_q, cls_next;

    logic [7:0]  b0, b1, b4, b5, b6, b7;
    logic [15:0] field45;
    logic        addr_ok, port_ok;

    assign b0 = hdr_lo[7:0];
    assign b1 = hdr_lo[15:8];
    assign b4 = hdr_hi[7:0];
    assign b5 = hdr_hi[15:8];
    assign b6 = hdr_hi[23:16];
    assign b7 = hdr_hi[31:24];
    assign field45 = {b4, b5};

    assign addr_ok = ((b0 == MC_PDELAY_O3) && (b1 == MC_PDELAY_O4)) ||
                     ((b0 == MC_MAIN_O3) && (b1 >= MC_MAIN_LO) && (b1 <= MC_MAIN_HI));
    assign port_ok = (field45 == PORT_EVENT) || (field45 == PORT_GENERAL);

    always_comb begin
        final_now = 1'b0;
        ptp_now   = 1'b0;
        cls_next  = cls_q;
        unique case (cls_q)
            CL_ETH_ADDR: cls_next = CL_ETH_TYPE;
            CL_ETH_TYPE: begin
                if (field45 == ETYPE_PTP) begin
                    final_now = 1'b1;
                    ptp_now   = 1'b1;
                end else if ((field45 == ETYPE_IPV4) && (b6 == IPV4_VER_IHL)) begin
                    cls_next = CL_IP_PROTO;
                end else begin
                    final_now = 1'b1;
                end
            end
            CL_IP_PROTO: begin
                if (b7 == PROTO_UDP) cls_next = CL_IP_DST_HI;
                else                 final_now = 1'b1;
            end
            CL_IP_DST_HI: begin
                if ((b6 == MC_OCT1) && (b7 == MC_OCT2)) cls_next = CL_UDP_PORT;
                else                                    final_now = 1'b1;
            end
            CL_UDP_PORT: begin
                final_now = 1'b1;
                ptp_now   = addr_ok && port_ok;
            end
            default: cls_next = CL_ETH_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CL_ETH_ADDR;
        end else if (beat_fire) begin
            if (final_now || beat_last) cls_q <= CL_ETH_ADDR;
            else                        cls_q <= cls_next;
        end
    end

endmodule

// File: rtl/ptp_beat_fifo.sv
module ptp_beat_fifo
    import ptp_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  beat_t wr_beat,
    input  logic  pop,
    output beat_t rd_beat,
    output logic  full,
    output logic  empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    beat_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign rd_beat = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= wr_beat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full)  wr_ptr <= bump(wr_ptr);
            if (pop && !empty)  rd_ptr <= bump(rd_ptr);
            unique case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ptp_rx_tagger.sv
module ptp_rx_tagger
    import ptp_rx_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     ts_in,
    input  logic [BEAT_W-1:0]   s_tdata,
    input  logic [KEEP_W-1:0]   s_tkeep,
    input  logic                s_tlast,
    input  logic                s_tvalid,
    output logic                s_tready,
    output logic [BEAT_W-1:0]   m_tdata,
    output logic [KEEP_W-1:0]   m_tkeep,
    output logic                m_tlast,
    output logic                m_tvalid,
    input  logic                m_tready
);

    tag_state_e state_q, state_d;

    logic            in_fire, collect_fire, out_pop;
    logic            fifo_full, fifo_empty;
    beat_t           fifo_in, fifo_out;
    logic            cls_final, cls_ptp;
    logic            qual_q, in_done_q;
    logic [TS_W-1:0] ts_q;
    logic [BEAT_W-1:0] status_word;

    assign in_fire      = s_tvalid && s_tready;
    assign collect_fire = in_fire && (state_q == ST_COLLECT);
    assign out_pop      = (state_q == ST_DRAIN) && !fifo_empty && m_tready;
    assign fifo_in      = '{data: s_tdata, keep: s_tkeep, last: s_tlast};

    assign status_word = {{(BEAT_W-32){1'b0}}, qual_q,
                          {(31-TS_HI_W){1'b0}}, ts_q[TS_W-1:BEAT_W]};

    ptp_beat_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_fire),
        .wr_beat (fifo_in),
        .pop     (out_pop),
        .rd_beat (fifo_out),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    ptp_hdr_classify u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_fire (collect_fire),
        .hdr_hi    (s_tdata[63:32]),
        .hdr_lo    (s_tdata[15:0]),
        .beat_last (s_tlast),
        .final_now (cls_final),
        .ptp_now   (cls_ptp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (collect_fire && (cls_final || s_tlast)) state_d = ST_PRE_LO;
            ST_PRE_LO:  if (m_tready) state_d = ST_PRE_HI;
            ST_PRE_HI:  if (m_tready) state_d = ST_DRAIN;
            ST_DRAIN:   if (out_pop && fifo_out.last) state_d = ST_COLLECT;
            default:    state_d = ST_COLLECT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // frame context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q      <= '0;
            qual_q    <= 1'b0;
            in_done_q <= 1'b0;
        end else begin
            if (collect_fire && fifo_empty) ts_q <= ts_in;
            if (collect_fire && (cls_final || s_tlast)) qual_q <= cls_final && cls_ptp;
            if (in_fire && s_tlast)              in_done_q <= 1'b1;
            else if (out_pop && fifo_out.last)   in_done_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tdata  = '0;
        m_tkeep  = '0;
        m_tlast  = 1'b0;
        unique case (state_q)
            ST_COLLECT: s_tready = !fifo_full;
            ST_PRE_LO: begin
                m_tvalid = 1'b1;
                m_tdata  = ts_q[BEAT_W-1:0];
                m_tkeep  = '1;
            end
            ST_PRE_HI: begin
                m_tvalid = 1'b1;
                m_tdata  = status_word;
                m_tkeep  = '1;
            end
            ST_DRAIN: begin
                s_tready = !fifo_full && !in_done_q;
                m_tvalid = !fifo_empty;
                m_tdata  = fifo_out.data;
                m_tkeep  = fifo_out.keep;
                m_tlast  = fifo_out.last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptp_rx_tagger_chk.sv
module ptp_rx_tagger_chk
    import ptp_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [TS_W-1:0]   ts_in,
    input logic              s_tlast,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic [BEAT_W-1:0] m_tdata,
    input logic [KEEP_W-1:0] m_tkeep,
    input logic              m_tlast,
    input logic              m_tvalid,
    input logic              m_tready
);

    logic [1:0]      out_idx;
    logic            first_q, busy_q;
    logic [TS_W-1:0] ts_cap;
    logic            s_hs, m_hs;

    assign s_hs = s_tvalid && s_tready;
    assign m_hs = m_tvalid && m_tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_idx <= '0;
            first_q <= 1'b1;
            busy_q  <= 1'b0;
            ts_cap  <= '0;
        end else begin
            if (m_hs) begin
                if (m_tlast)            out_idx <= '0;
                else if (out_idx != 2'd2) out_idx <= out_idx + 1'b1;
            end
            if (s_hs) begin
                if (first_q) ts_cap <= ts_in;
                first_q <= s_tlast;
            end
            if (s_hs && s_tlast)     busy_q <= 1'b1;
            else if (m_hs && m_tlast) busy_q <= 1'b0;
        end
    end

    assert_prefix_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && out_idx == 2'd0) |->
            (m_tdata == ts_cap[BEAT_W-1:0]) && (&m_tkeep) && !m_tlast);

    assert_prefix_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && out_idx == 2'd1) |->
            (m_tdata[15:0] == ts_cap[TS_W-1:BEAT_W]) && (m_tdata[30:16] == '0) &&
            (m_tdata[63:32] == '0) && (&m_tkeep) && !m_tlast);

    assert_closed_in_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && out_idx != 2'd2) |-> !s_tready);

    assert_closed_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !s_tready);

    assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=>
            m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

endmodule

bind ptp_rx_tagger ptp_rx_tagger_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts_in    (ts_in),
    .s_tlast  (s_tlast),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tkeep  (m_tkeep),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready)
);

// File: tb/ptp_rx_tagger_test.sv
`timescale 1ns/1ps
module ptp_rx_tagger_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] ts_in = '0;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b0;

    always #2.5 clk = ~clk;

    ptp_rx_tagger uut (
        .clk(clk), .rst_n(rst_n), .ts_in(ts_in),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0]  fr [0:127];
    int          fr_len;
    int          acc_cnt;
    bit          sent_done;
    logic [63:0] got_d [0:31];
    logic [7:0]  got_k [0:31];
    logic        got_l [0:31];
    int          got_n;
    int          first_acc;
    int          r8_bad;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < 128; i++) fr[i] = 8'(i * 7 + 3);
        fr_len = len;
    endtask

    task automatic build_l2(input logic [15:0] et, input int len);
        fill(len);
        fr[12] = et[15:8];
        fr[13] = et[7:0];
    endtask

    task automatic build_ip(input logic [7:0] vihl, input logic [7:0] proto,
                            input logic [7:0] o1, input logic [7:0] o2,
                            input logic [7:0] o3, input logic [7:0] o4,
                            input logic [15:0] port, input int len);
        fill(len);
        fr[12] = 8'h08; fr[13] = 8'h00;
        fr[14] = vihl;
        fr[23] = proto;
        fr[30] = o1; fr[31] = o2; fr[32] = o3; fr[33] = o4;
        fr[36] = port[15:8]; fr[37] = port[7:0];
    endtask

    function automatic logic [63:0] beat_data(input int b);
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[8*j +: 8] = fr[8*b + j];
        return d;
    endfunction

    function automatic logic [7:0] beat_keep(input int b);
        logic [7:0] k;
        for (int j = 0; j < 8; j++) k[j] = (8*b + j) < fr_len;
        return k;
    endfunction

    task automatic send_frame();
        int nb = (fr_len + 7) / 8;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = beat_data(b);
            s_tkeep  = beat_keep(b);
            s_tlast  = (b == nb - 1);
            #1;
            while (!s_tready) begin
                @(negedge clk);
                #1;
            end
            acc_cnt++;
        end
        @(negedge clk);
        s_tvalid  = 1'b0;
        s_tlast   = 1'b0;
        sent_done = 1'b1;
    endtask

    task automatic recv_frame(input int mode);
        bit done = 1'b0;
        int cyc = 0;
        got_n = 0; first_acc = -1; r8_bad = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            case (mode)
                1:       m_tready = cyc[0];
                2:       m_tready = (cyc > 8);
                default: m_tready = 1'b1;
            endcase
            #2;
            if (sent_done && s_tready) r8_bad++;
            if (m_tvalid) begin
                if (first_acc < 0) first_acc = acc_cnt;
                if (got_n < 2 && s_tready) r8_bad++;
                if (m_tready) begin
                    got_d[got_n] = m_tdata;
                    got_k[got_n] = m_tkeep;
                    got_l[got_n] = m_tlast;
                    got_n++;
                    if (m_tlast) done = 1'b1;
                end
            end
        end
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    task automatic run_frame(input logic [79:0] ts, input bit q, input string qtag,
                             input int exp_acc, input int mode, input string name);
        int nb = (fr_len + 7) / 8;
        logic [63:0] w1;
        ts_in = ts; acc_cnt = 0; sent_done = 1'b0;
        fork
            send_frame();
            recv_frame(mode);
        join
        w1 = {32'h0, q, 15'h0, ts[79:64]};
        check(got_n == nb + 2, "R3", {name, " word count"}, 64'(got_n), 64'(nb + 2));
        if (got_n == nb + 2) begin
            check(got_d[0] == ts[63:0] && got_k[0] == 8'hFF && !got_l[0], "R1",
                  {name, " prefix word 0"}, got_d[0], ts[63:0]);
            check(got_d[1] == w1 && got_k[1] == 8'hFF && !got_l[1], "R2",
                  {name, " prefix word 1"}, got_d[1], w1);
            check(got_d[1][31] == q, qtag, {name, " qualifier"},
                  64'(got_d[1][31]), 64'(q));
            for (int b = 0; b < nb; b++)
                check(got_d[b+2] == beat_data(b) && got_k[b+2] == beat_keep(b) &&
                      got_l[b+2] == (b == nb - 1), mode == 1 ? "R9" : "R3",
                      {name, " data beat"}, got_d[b+2], beat_data(b));
        end
        check(first_acc == exp_acc, "R10", {name, " beats accepted before prefix"},
              64'(first_acc), 64'(exp_acc));
        check(r8_bad == 0, "R8", {name, " input open during prefix or after tlast"},
              64'(r8_bad), 64'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #2;
        check(!m_tvalid, "R8", "reset m_tvalid", 64'(m_tvalid), 64'd0);
        check(s_tready,  "R8", "reset s_tready", 64'(s_tready), 64'd1);
    endtask

    task automatic t_l2_ptp();
        build_l2(16'h88F7, 60);
        run_frame(80'hA1B2_0123_4567_89AB_CDEF, 1'b1, "R4", 2, 0, "l2 ptp");
        build_l2(16'h88F7, 14);   // ends on the deciding beat
        run_frame(80'h0F0F_1111_2222_3333_4444, 1'b1, "R4", 2, 0, "l2 ptp 14B");
    endtask

    task automatic t_ipv4_ptp();
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd129, 16'd319, 70);
        run_frame(80'h5555_DEAD_BEEF_0000_0001, 1'b1, "R5", 5, 0, "ipv4 event");
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd132, 16'd320, 66);
        run_frame(80'h1234_0000_0000_0000_0002, 1'b1, "R5", 5, 0, "ipv4 .132");
    endtask

    task automatic t_ipv4_stall();
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd0, 8'd107, 16'd320, 75);
        run_frame(80'hFFFF_8000_0000_0000_0003, 1'b1, "R5", 5, 1, "ipv4 pdelay stall");
    endtask

    task automatic t_rejects();
        build_l2(16'h86DD, 64);
        run_frame(80'h0001_0000_0000_0000_0004, 1'b0, "R6", 2, 0, "other etype");
        build_ip(8'h46, 8'd17, 8'd224, 8'd0, 8'd1, 8'd129, 16'd319, 64);
        run_frame(80'h0002_0000_0000_0000_0005, 1'b0, "R6", 2, 0, "ihl 6");
        build_ip(8'h45, 8'd6, 8'd224, 8'd0, 8'd1, 8'd129, 16'd319, 64);
        run_frame(80'h0003_0000_0000_0000_0006, 1'b0, "R6", 3, 0, "tcp proto");
        build_ip(8'h45, 8'd17, 8'd225, 8'd0, 8'd1, 8'd129, 16'd319, 64);
        run_frame(80'h0004_0000_0000_0000_0007, 1'b0, "R6", 4, 0, "addr 225");
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd133, 16'd319, 64);
        run_frame(80'h0005_0000_0000_0000_0008, 1'b0, "R6", 5, 0, "addr .133");
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd130, 16'd321, 64);
        run_frame(80'h0006_0000_0000_0000_0009, 1'b0, "R6", 5, 0, "port 321");
    endtask

    task automatic t_short();
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd129, 16'd319, 20);
        run_frame(80'h0007_0000_0000_0000_000A, 1'b0, "R7", 3, 0, "short ipv4");
        build_l2(16'h88F7, 6);
        run_frame(80'h0008_0000_0000_0000_000B, 1'b0, "R7", 1, 0, "single beat");
    endtask

    task automatic t_slow_sink();
        build_ip(8'h45, 8'd17, 8'd224, 8'd0, 8'd1, 8'd131, 16'd319, 90);
        run_frame(80'h0009_0000_0000_0000_000C, 1'b1, "R5", 5, 2, "slow sink");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_l2_ptp();
        t_ipv4_ptp();
        t_ipv4_stall();
        t_rejects();
        t_short();
        t_slow_sink();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule